// File: doc/BRIEF.md
# Lost-Tone Supervision Timer

This block watches the receive side of a tone signalling path and reports when a valid tone has been missing for a programmed time. Software writes an 8-bit period through the register bus. That write only primes the timer. The timer does not count until a frequency measurement has completed successfully. Every later successful measurement reloads the period and starts the run-down again.

Time is counted in ticks of an enable that a shared prescaler supplies. The count advances only while the receiver reports the signal as unreadable. As a result, the run-down begins at the last good measurement when no signal is present, or at the moment the signal fades.

When the period runs out, the block raises a one-cycle expiry pulse, which feeds the status and interrupt logic. The pulse is held back if a frequency measurement is more than three quarters complete at that moment. A held-back expiry is released if that measurement is then aborted. It is dropped if the measurement completes or if software writes a new period. The timer fires at most once per arming.

Top module: `notone_timer`

## Requirements
- R1: After reset `expire_o` is 0, the stored period is 0 and the timer is not armed. The first tick after the first successful measurement therefore fires.
- R2: Before the first successful measurement after reset or after a period write, no number of ticks produces an expiry.
- R3: Once armed with period P ≥ 1, the timer fires on the P-th counted tick, with `expire_o` high in the cycle after that tick is sampled. A period of 0 fires on the first counted tick, the same as a period of 1.
- R4: Each `meas_done_i` reloads the full period and restarts the run-down. Ticks counted before it do not carry over.
- R5: Ticks sampled while `sig_valid_i` is 1 are not counted. The run-down proceeds only while the signal is unreadable.
- R6: The timer fires at most once per arming. After firing it stays idle through any number of ticks until the next `meas_done_i`.
- R7: If the expiring tick coincides with `meas_busy_i`=1 and `meas_frac_i` greater than 3/4 of full scale (greater than 12 for a 4-bit fraction), no pulse is produced. A fraction of exactly 12 does not suppress the pulse.
- R8: A suppressed expiry is raised as a pulse in the cycle after `meas_abort_i` is sampled. It is cancelled, with no pulse, if `meas_done_i` arrives first, and that measurement re-arms the timer.
- R9: A period write (`per_wr_i`) drops a pending suppressed expiry and disarms the timer until the next successful measurement. No pulse appears in the cycle after a write.
- R10: `expire_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also used as the general reset |
| per_wr_i | input | 1 | Period write strobe from the register bus |
| per_data_i | input | PERIOD_W | Period in ticks |
| tick_i | input | 1 | Time-unit enable from the prescaler |
| sig_valid_i | input | 1 | 1 while the received signal is readable |
| meas_done_i | input | 1 | Successful frequency measurement completed |
| meas_busy_i | input | 1 | A frequency measurement is in progress |
| meas_frac_i | input | FRAC_W | Progress of the measurement in progress, as a fraction of 2^FRAC_W |
| meas_abort_i | input | 1 | The measurement in progress was abandoned |
| expire_o | output | 1 | One-cycle lost-tone expiry pulse |

## Verification
The bench builds the block with PERIOD_W=8, FRAC_W=4 and the late-measurement guard enabled. With a 4-bit fraction the three-quarter threshold falls on the exact code 12, so both sides of the boundary, 12 and 13, can be driven directly. Small periods of 0 to 4 ticks keep every arming, restart, fade and deferred-abort sequence within a few dozen cycles. Because the tick is driven by hand, the firing cycle can be counted exactly rather than inferred.

// File: rtl/notone_timer_pkg.sv
package notone_timer_pkg;

   typedef enum logic [1:0] {
      NT_IDLE = 2'd0,
      NT_RUN  = 2'd1,
      NT_HOLD = 2'd2
   } nt_state_e;

endpackage

// File: rtl/notone_period_reg.sv
module notone_period_reg #(
   parameter int PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [PERIOD_W-1:0] data_i,
   output logic [PERIOD_W-1:0] period_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_o <= '0;
      end else if (wr_i) begin
         period_o <= data_i;
      end
   end

endmodule

// File: rtl/notone_downcount.sv
module notone_downcount #(
   parameter int PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [PERIOD_W-1:0] load_val_i,
   input  logic                dec_i,
   output logic                last_o
);

   localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

   logic [PERIOD_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i && (cnt_q > ONE)) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   // Zero and one both mean "this tick ends the period".
   assign last_o = (cnt_q <= ONE);

endmodule

// File: rtl/notone_late_gate.sv
module notone_late_gate #(
   parameter int FRAC_W   = 4,
   parameter bit GUARD_EN = 1'b1
) (
   input  logic              busy_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              late_o
);

   localparam logic [FRAC_W-1:0] THR = FRAC_W'(3 * (2 ** (FRAC_W - 2)));

   generate
      if (GUARD_EN) begin : g_guard
         assign late_o = busy_i && (frac_i > THR);
      end else begin : g_noguard
         logic unused_in;
         assign unused_in = busy_i ^ (^frac_i);
         assign late_o    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/notone_timer.sv
module notone_timer
   import notone_timer_pkg::*;
#(
   parameter int PERIOD_W = 8,
   parameter int FRAC_W   = 4,
   parameter bit GUARD_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                per_wr_i,
   input  logic [PERIOD_W-1:0] per_data_i,
   input  logic                tick_i,
   input  logic                sig_valid_i,
   input  logic                meas_done_i,
   input  logic                meas_busy_i,
   input  logic [FRAC_W-1:0]   meas_frac_i,
   input  logic                meas_abort_i,
   output logic                expire_o
);

   generate
      if (PERIOD_W < 1 || PERIOD_W > 32) begin : g_bad_period
         $error("notone_timer: PERIOD_W must be 1..32");
      end
      if (FRAC_W < 2 || FRAC_W > 16) begin : g_bad_frac
         $error("notone_timer: FRAC_W must be 2..16");
      end
   endgenerate

   nt_state_e           st_q, st_d;
   logic [PERIOD_W-1:0] period;
   logic                cnt_load, cnt_dec, cnt_last;
   logic                late, fire, expire_q;

   notone_period_reg #(.PERIOD_W(PERIOD_W)) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (per_wr_i),
      .data_i   (per_data_i),
      .period_o (period)
   );

   notone_downcount #(.PERIOD_W(PERIOD_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cnt_load),
      .load_val_i (period),
      .dec_i      (cnt_dec),
      .last_o     (cnt_last)
   );

   notone_late_gate #(.FRAC_W(FRAC_W), .GUARD_EN(GUARD_EN)) u_late (
      .busy_i (meas_busy_i),
      .frac_i (meas_frac_i),
      .late_o (late)
   );

   always_comb begin
      st_d     = st_q;
      cnt_load = 1'b0;
      cnt_dec  = 1'b0;
      fire     = 1'b0;
      if (per_wr_i) begin
         st_d = NT_IDLE;
      end else if (meas_done_i) begin
         st_d     = NT_RUN;
         cnt_load = 1'b1;
      end else begin
         unique case (st_q)
            NT_RUN: begin
               if (tick_i && !sig_valid_i) begin
                  if (!cnt_last) begin
                     cnt_dec = 1'b1;
                  end else if (late) begin
                     st_d = NT_HOLD;
                  end else begin
                     fire = 1'b1;
                     st_d = NT_IDLE;
                  end
               end
            end
            NT_HOLD: begin
               if (meas_abort_i) begin
                  fire = 1'b1;
                  st_d = NT_IDLE;
               end
            end
            default: st_d = NT_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= NT_IDLE;
         expire_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         expire_q <= fire;
      end
   end

   assign expire_o = expire_q;

endmodule

// File: rtl/notone_timer_chk.sv
module notone_timer_chk #(
   parameter int FRAC_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              per_wr_i,
   input logic              tick_i,
   input logic              meas_done_i,
   input logic              meas_busy_i,
   input logic [FRAC_W-1:0] meas_frac_i,
   input logic              meas_abort_i,
   input logic              expire_o
);

   localparam logic [FRAC_W-1:0] THR = FRAC_W'(3 * (2 ** (FRAC_W - 2)));

   logic armed_seen, fired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_seen <= 1'b0;
         fired      <= 1'b0;
      end else begin
         if (per_wr_i)         armed_seen <= 1'b0;
         else if (meas_done_i) armed_seen <= 1'b1;
         if (per_wr_i || meas_done_i) fired <= 1'b0;
         else if (expire_o)           fired <= 1'b1;
      end
   end

   a_r2_needs_measurement: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> armed_seen);

   a_r6_once_per_arming: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> !fired);

   a_r7_late_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_busy_i && (meas_frac_i > THR) && !meas_abort_i) |=> !expire_o);

   a_r9_write_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      per_wr_i |=> !expire_o);

   a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !expire_o);

   a_r3_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> $past(tick_i || meas_abort_i));

endmodule

bind notone_timer notone_timer_chk #(.FRAC_W(FRAC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .per_wr_i     (per_wr_i),
   .tick_i       (tick_i),
   .meas_done_i  (meas_done_i),
   .meas_busy_i  (meas_busy_i),
   .meas_frac_i  (meas_frac_i),
   .meas_abort_i (meas_abort_i),
   .expire_o     (expire_o)
);

// File: tb/notone_timer_tb.sv
`timescale 1ns/1ps
module notone_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       per_wr = 1'b0;
   logic [7:0] per_data = '0;
   logic       tick = 1'b0;
   logic       sig_valid = 1'b0;
   logic       meas_done = 1'b0;
   logic       meas_busy = 1'b0;
   logic [3:0] meas_frac = '0;
   logic       meas_abort = 1'b0;
   logic       expire;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   notone_timer #(.PERIOD_W(8), .FRAC_W(4), .GUARD_EN(1'b1)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .per_wr_i     (per_wr),
      .per_data_i   (per_data),
      .tick_i       (tick),
      .sig_valid_i  (sig_valid),
      .meas_done_i  (meas_done),
      .meas_busy_i  (meas_busy),
      .meas_frac_i  (meas_frac),
      .meas_abort_i (meas_abort),
      .expire_o     (expire)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One clock: inputs already set at a falling edge, result sampled at the next one.
   task automatic step(output logic e);
      @(posedge clk);
      @(negedge clk);
      e = expire;
   endtask

   task automatic write_period(input logic [7:0] p);
      logic e;
      per_wr = 1'b1; per_data = p;
      step(e);
      per_wr = 1'b0;
      check("R9 no pulse after write", e, 0);
   endtask

   task automatic measure_ok();
      logic e;
      meas_done = 1'b1;
      step(e);
      meas_done = 1'b0;
   endtask

   // Apply n ticks; report the index (1-based) of the first pulse and the pulse count.
   task automatic ticks(input int n, output int first, output int count);
      logic e;
      first = 0; count = 0;
      for (int i = 1; i <= n; i++) begin
         tick = 1'b1;
         step(e);
         tick = 1'b0;
         if (e) begin
            count++;
            if (first == 0) first = i;
         end
      end
   endtask

   task automatic t_reset();
      int f, c;
      check("R1 expire low after reset", expire, 0);
      ticks(6, f, c);
      check("R2 no expiry before any measurement", c, 0);
      measure_ok();
      ticks(1, f, c);
      check("R1 reset period is zero, fires on first tick", f, 1);
   endtask

   task automatic t_period();
      int f, c;
      write_period(8'd3);
      ticks(5, f, c);
      check("R2 primed but not armed", c, 0);
      measure_ok();
      ticks(3, f, c);
      check("R3 period 3 fires on third tick", f, 3);
      ticks(10, f, c);
      check("R6 idle after firing", c, 0);
      measure_ok();
      ticks(4, f, c);
      check("R6 rearmed by measurement", f, 3);
      write_period(8'd0);
      measure_ok();
      ticks(2, f, c);
      check("R3 period 0 fires on first tick", f, 1);
      check("R10 single pulse", c, 1);
   endtask

   task automatic t_restart();
      int f, c;
      write_period(8'd4);
      measure_ok();
      ticks(3, f, c);
      check("R4 no pulse before period", c, 0);
      measure_ok();
      ticks(3, f, c);
      check("R4 restart discards earlier ticks", c, 0);
      ticks(1, f, c);
      check("R4 fires four ticks after restart", f, 1);
   endtask

   task automatic t_valid();
      int f, c;
      write_period(8'd2);
      sig_valid = 1'b1;
      measure_ok();
      ticks(6, f, c);
      check("R5 readable signal holds timer", c, 0);
      sig_valid = 1'b0;
      ticks(2, f, c);
      check("R5 run-down from fade", f, 2);
   endtask

   task automatic t_defer();
      int f, c;
      logic e, e2;
      write_period(8'd1);
      measure_ok();
      meas_busy = 1'b1; meas_frac = 4'd13;
      ticks(4, f, c);
      check("R7 late measurement withholds expiry", c, 0);
      meas_abort = 1'b1;
      step(e);
      meas_abort = 1'b0; meas_busy = 1'b0; meas_frac = '0;
      check("R8 abort releases expiry", e, 1);
      step(e2);
      check("R10 pulse lasts one cycle", e2, 0);
      // exactly three quarters does not withhold
      measure_ok();
      meas_busy = 1'b1; meas_frac = 4'd12;
      ticks(1, f, c);
      meas_busy = 1'b0; meas_frac = '0;
      check("R7 fraction at threshold still fires", f, 1);
      // late, then measurement completes: cancelled and rearmed
      measure_ok();
      meas_busy = 1'b1; meas_frac = 4'd15;
      ticks(1, f, c);
      meas_busy = 1'b0; meas_frac = '0;
      check("R7 fraction 15 withholds", c, 0);
      meas_done = 1'b1;
      step(e);
      meas_done = 1'b0;
      check("R8 completion cancels held expiry", e, 0);
      ticks(1, f, c);
      check("R8 completion rearms", f, 1);
   endtask

   task automatic t_write_clear();
      int f, c;
      logic e;
      write_period(8'd1);
      measure_ok();
      meas_busy = 1'b1; meas_frac = 4'd14;
      ticks(1, f, c);
      check("R7 held before write", c, 0);
      write_period(8'd1);
      meas_abort = 1'b1;
      step(e);
      meas_abort = 1'b0; meas_busy = 1'b0; meas_frac = '0;
      check("R9 write drops held expiry", e, 0);
      ticks(3, f, c);
      check("R9 write disarms", c, 0);
      measure_ok();
      ticks(1, f, c);
      check("R9 rearm after write", f, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_period();
      t_restart();
      t_valid();
      t_defer();
      t_write_clear();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule